// File: doc/BRIEF.md
# Linear Frequency Sweep Sequencer

This block steps the tuning word of a direct digital synthesis core through a linear frequency sweep, all in the master clock domain. Software supplies a starting tuning word, an increment, the number of increments, a dwell time and a few mode bits. Two asynchronous pins drive the sweep at run time:

- **Start/step pin.** It initialises and starts the sweep. In external-step mode it also advances the frequency by one increment on each later rising edge.
- **Abort pin.** A rising edge stops the sweep at once and parks the output at midscale.

The current tuning word feeds an internal phase accumulator. The top bits of the accumulator form the DAC code; they stand in for a sine lookup, which lives outside this block. An optional inverted-MSB output and an optional status pulse output report the waveform and the sweep progress.

Top module: `sweep_seq_top`

## Requirements
- R1: After reset the tuning word is 0, the DAC code is 512 (midscale), and the status output and MSB output are both 0.
- R2: A start edge loads the starting tuning word and clears the phase accumulator. After that, the accumulator adds the current tuning word every cycle, and the DAC code is the top DAC_W bits of the accumulator.
- R3: In auto mode (`cfg_auto`=1) each frequency is held for `cfg_dwell` cycles, or 1 cycle when `cfg_dwell` is 0. After that hold, the step word is added.
- R4: In external mode (`cfg_auto`=0) the tuning word changes only on a later rising start edge, and each such edge adds one step. No amount of elapsed time advances the word.
- R5: When the `cfg_count`-th increment is applied, the sweep ends and the last word is held. A later start edge restarts the sweep from the starting word. With `cfg_count`=0 the sweep ends in the same cycle it starts.
- R6: A rising abort edge sets the tuning word to 0 and the DAC code to 512, and stops any sweep. If a start edge arrives in the same cycle, the abort wins.
- R7: `stat_out` is 0 whenever `cfg_stat_en`=0. When it is enabled, it carries a one-cycle pulse either at each increment (`cfg_stat_sel`=1) or at the end of the sweep (`cfg_stat_sel`=0). The pulse appears in the same cycle as the new tuning word.
- R8: `msb_out` equals the inverse of bit DAC_W-1 of the DAC code when `cfg_msb_en`=1, and is 0 when `cfg_msb_en`=0.
- R9: Each pin passes through a two-flop synchroniser and a rising-edge detector. A pin that rises before clock edge 1 takes effect at edge 3. A pin that stays high acts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_start | input | TUNE_W | Starting tuning word |
| cfg_step | input | TUNE_W | Increment added at each step |
| cfg_count | input | CNT_W | Number of increments in a sweep |
| cfg_dwell | input | DWELL_W | Cycles per frequency in auto mode |
| cfg_auto | input | 1 | 1 = auto stepping, 0 = step on each pin edge |
| cfg_stat_en | input | 1 | Enables the status output |
| cfg_stat_sel | input | 1 | 1 = pulse per increment, 0 = pulse at end of sweep |
| cfg_msb_en | input | 1 | Enables the MSB output |
| start_pin | input | 1 | Asynchronous start/step pin |
| abort_pin | input | 1 | Asynchronous abort pin |
| tune_word | output | TUNE_W | Current tuning word |
| dac_code | output | DAC_W | DAC code from the accumulator |
| msb_out | output | 1 | Inverted DAC MSB, gated |
| stat_out | output | 1 | Sweep status pulse, gated |

## Verification
The bench builds the block with its defaults: a 24-bit tuning word, a 10-bit code, a 12-bit count and a 16-bit dwell.

- **Phase model.** With these widths the DAC code is the running sum of tuning words shifted right by 14. A plain integer model can therefore predict every code sample.
- **Sweep lengths.** Short dwell values (0, 1 and 4) and counts of 0 to 5 put every step boundary and every end-of-sweep inside a few dozen cycles.
- **Boundary cases.** These include the zero-dwell case, the zero-count case and an abort that coincides with a start.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sweep_st_e;

endpackage

// File: rtl/sweep_edge_sync.sv
module sweep_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin_a};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = st_q.sync[STAGES-1] & ~st_q.prev;

    AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R9

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
    import sweep_pkg::*;
#(
    parameter int TUNE_W  = 24,
    parameter int CNT_W   = 12,
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TUNE_W-1:0]  cfg_start,
    input  logic [TUNE_W-1:0]  cfg_step,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic [DWELL_W-1:0] cfg_dwell,
    input  logic               cfg_auto,
    input  logic               start_rise,
    input  logic               abort_rise,
    output logic [TUNE_W-1:0]  tune_q,
    output logic               incr_q,
    output logic               eos_q,
    output logic               acc_clr,
    output logic               acc_mid
);

    typedef struct packed {
        sweep_st_e          state;
        logic [TUNE_W-1:0]  tune;
        logic [CNT_W-1:0]   step_cnt;
        logic [DWELL_W-1:0] dwell_cnt;
        logic               incr;
        logic               eos;
    } ctrl_s;

    ctrl_s st_d, st_q;
    logic  dwell_last;
    logic  do_step;
    logic  ext_step_ok;

    assign ext_step_ok = (st_q.state == ST_RUN) && !cfg_auto;

    always_comb begin
        st_d       = st_q;
        st_d.incr  = 1'b0;
        st_d.eos   = 1'b0;
        acc_clr    = 1'b0;
        acc_mid    = 1'b0;
        do_step    = 1'b0;
        dwell_last = (cfg_dwell == '0) ||
                     (st_q.dwell_cnt == cfg_dwell - DWELL_W'(1));

        if (abort_rise) begin
            st_d.state     = ST_IDLE;
            st_d.tune      = '0;
            st_d.step_cnt  = '0;
            st_d.dwell_cnt = '0;
            acc_mid        = 1'b1;
        end else if (start_rise && !ext_step_ok) begin
            st_d.tune      = cfg_start;
            st_d.step_cnt  = '0;
            st_d.dwell_cnt = '0;
            acc_clr        = 1'b1;
            if (cfg_count == '0) begin
                st_d.state = ST_IDLE;
                st_d.eos   = 1'b1;
            end else begin
                st_d.state = ST_RUN;
            end
        end else if (st_q.state == ST_RUN) begin
            if (cfg_auto) begin
                if (dwell_last) begin
                    do_step        = 1'b1;
                    st_d.dwell_cnt = '0;
                end else begin
                    st_d.dwell_cnt = st_q.dwell_cnt + DWELL_W'(1);
                end
            end else begin
                do_step = start_rise;
            end
        end

        if (do_step) begin
            st_d.tune     = st_q.tune + cfg_step;
            st_d.step_cnt = st_q.step_cnt + CNT_W'(1);
            st_d.incr     = 1'b1;
            if (st_q.step_cnt + CNT_W'(1) >= cfg_count) begin
                st_d.state = ST_IDLE;
                st_d.eos   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tune_q = st_q.tune;
    assign incr_q = st_q.incr;
    assign eos_q  = st_q.eos;

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rise && !abort_rise && !ext_step_ok) |=> (tune_q == $past(cfg_start))); // R2

    AST_STEP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        incr_q |-> (tune_q == $past(tune_q) + $past(cfg_step))); // R3

    AST_EXT_NO_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_step_ok && !start_rise && !abort_rise) |=> $stable(tune_q)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.state == ST_IDLE) && !start_rise && !abort_rise) |=> $stable(tune_q)); // R5

    AST_EOS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        eos_q |-> (st_q.state == ST_IDLE)); // R5

    AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        abort_rise |=> ((st_q.state == ST_IDLE) && (tune_q == '0) && !incr_q)); // R6

endmodule

// File: rtl/sweep_phase_acc.sv
module sweep_phase_acc #(
    parameter int TUNE_W = 24,
    parameter int DAC_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TUNE_W-1:0] tune,
    input  logic              acc_clr,
    input  logic              acc_mid,
    output logic [DAC_W-1:0]  code
);

    localparam logic [TUNE_W-1:0] MID = TUNE_W'(1) << (TUNE_W - 1);

    typedef struct packed {
        logic [TUNE_W-1:0] phase;
    } acc_s;

    acc_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc_mid) begin
            st_d.phase = MID;
        end else if (acc_clr) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + tune;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: MID};
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.phase[TUNE_W-1 -: DAC_W];

    AST_MID_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        acc_mid |=> (code == DAC_W'(1) << (DAC_W - 1))); // R6

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clr && !acc_mid) |=> (code == '0)); // R2

endmodule

// File: rtl/sweep_seq_top.sv
module sweep_seq_top #(
    parameter int TUNE_W      = 24,
    parameter int DAC_W       = 10,
    parameter int CNT_W       = 12,
    parameter int DWELL_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TUNE_W-1:0]  cfg_start,
    input  logic [TUNE_W-1:0]  cfg_step,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic [DWELL_W-1:0] cfg_dwell,
    input  logic               cfg_auto,
    input  logic               cfg_stat_en,
    input  logic               cfg_stat_sel,
    input  logic               cfg_msb_en,
    input  logic               start_pin,
    input  logic               abort_pin,
    output logic [TUNE_W-1:0]  tune_word,
    output logic [DAC_W-1:0]   dac_code,
    output logic               msb_out,
    output logic               stat_out
);

    logic start_rise, abort_rise;
    logic incr_q, eos_q, acc_clr, acc_mid;

    sweep_edge_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
        .clk(clk), .rst_n(rst_n), .pin_a(start_pin), .rise(start_rise)
    );

    sweep_edge_sync #(.STAGES(SYNC_STAGES)) u_abort_sync (
        .clk(clk), .rst_n(rst_n), .pin_a(abort_pin), .rise(abort_rise)
    );

    sweep_ctrl #(.TUNE_W(TUNE_W), .CNT_W(CNT_W), .DWELL_W(DWELL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_start(cfg_start), .cfg_step(cfg_step), .cfg_count(cfg_count),
        .cfg_dwell(cfg_dwell), .cfg_auto(cfg_auto),
        .start_rise(start_rise), .abort_rise(abort_rise),
        .tune_q(tune_word), .incr_q(incr_q), .eos_q(eos_q),
        .acc_clr(acc_clr), .acc_mid(acc_mid)
    );

    sweep_phase_acc #(.TUNE_W(TUNE_W), .DAC_W(DAC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .tune(tune_word),
        .acc_clr(acc_clr), .acc_mid(acc_mid), .code(dac_code)
    );

    assign msb_out  = cfg_msb_en & ~dac_code[DAC_W-1];
    assign stat_out = cfg_stat_en & (cfg_stat_sel ? incr_q : eos_q);

    AST_EOS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eos_q |=> !eos_q); // R7

endmodule

// File: tb/sweep_seq_top_tb.sv
module sweep_seq_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cfg_start = '0, cfg_step = '0;
    logic [11:0] cfg_count = '0;
    logic [15:0] cfg_dwell = '0;
    logic        cfg_auto = 1'b1, cfg_stat_en = 1'b1, cfg_stat_sel = 1'b1, cfg_msb_en = 1'b1;
    logic        start_pin = 1'b0, abort_pin = 1'b0;
    logic [23:0] tune_word;
    logic [9:0]  dac_code;
    logic        msb_out, stat_out;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    sweep_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_step(cfg_step),
        .cfg_count(cfg_count), .cfg_dwell(cfg_dwell), .cfg_auto(cfg_auto),
        .cfg_stat_en(cfg_stat_en), .cfg_stat_sel(cfg_stat_sel), .cfg_msb_en(cfg_msb_en),
        .start_pin(start_pin), .abort_pin(abort_pin), .tune_word(tune_word),
        .dac_code(dac_code), .msb_out(msb_out), .stat_out(stat_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // raise a pin at a falling edge and return at the falling edge after the third rising edge
    task automatic raise_start();
        @(negedge clk) start_pin = 1'b1;
        repeat (3) @(negedge clk);
        start_pin = 1'b0;
    endtask

    task automatic idle_low(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tune_word == 24'h0, "R1", "tune", tune_word, 0);
        chk(dac_code == 10'd512, "R1", "dac", dac_code, 512);
        chk(stat_out == 1'b0, "R1", "stat", stat_out, 0);
        chk(msb_out == 1'b0, "R1", "msb", msb_out, 0);
    endtask

    // R9 latency: no effect at edge 2, effect at edge 3, held pin acts once
    task automatic t_latency();
        cfg_auto = 1'b0; cfg_count = 12'd3; cfg_start = 24'h123456; cfg_step = 24'h000100;
        @(negedge clk) start_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk(tune_word == 24'h0, "R9", "before edge3", tune_word, 0);
        @(negedge clk);
        chk(tune_word == 24'h123456, "R9", "at edge3", tune_word, 24'h123456);
        repeat (10) @(negedge clk);
        chk(tune_word == 24'h123456, "R9", "held pin", tune_word, 24'h123456);
        start_pin = 1'b0;
        abort_pin = 1'b1; repeat (3) @(negedge clk); abort_pin = 1'b0;
        idle_low(3);
    endtask

    // auto sweep with model of tune, status and phase
    task automatic t_auto(input logic [23:0] sw, input logic [23:0] st, input int cnt,
                          input int dw, input bit sel, input string req);
        int d;
        logic [23:0] ph, et;
        int errs_t, errs_s, errs_c;
        d = (dw == 0) ? 1 : dw;
        cfg_auto = 1'b1; cfg_start = sw; cfg_step = st; cfg_count = 12'(cnt);
        cfg_dwell = 16'(dw); cfg_stat_en = 1'b1; cfg_stat_sel = sel;
        idle_low(3);
        raise_start();
        ph = '0; errs_t = 0; errs_s = 0; errs_c = 0;
        for (int j = 0; j < d * cnt + 8; j++) begin
            int k;
            bit es;
            k = (j / d > cnt) ? cnt : j / d;
            et = sw + 24'(st * 24'(k));
            es = sel ? (j > 0 && (j % d) == 0 && (j / d) <= cnt) : (j == d * cnt);
            if (tune_word != et) begin
                errs_t++;
                if (errs_t == 1) chk(0, req, "tune", tune_word, et);
            end
            if (stat_out != es) begin
                errs_s++;
                if (errs_s == 1) chk(0, "R7", "stat pulse", stat_out, es);
            end
            if (dac_code != ph[23:14]) begin
                errs_c++;
                if (errs_c == 1) chk(0, "R2", "dac code", dac_code, ph[23:14]);
            end
            ph = ph + et;
            @(negedge clk);
        end
        if (errs_t == 0) chk(1, req, "tune", 0, 0);
        if (errs_s == 0) chk(1, "R7", "stat pulse", 0, 0);
        if (errs_c == 0) chk(1, "R2", "dac code", 0, 0);
    endtask

    task automatic t_ext();
        cfg_auto = 1'b0; cfg_start = 24'h040000; cfg_step = 24'h002000; cfg_count = 12'd2;
        cfg_dwell = 16'd1; cfg_stat_en = 1'b1; cfg_stat_sel = 1'b1;
        idle_low(3);
        raise_start();
        chk(tune_word == 24'h040000, "R4", "ext start", tune_word, 24'h040000);
        chk(stat_out == 1'b0, "R7", "no pulse at start", stat_out, 0);
        begin
            int hits = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (tune_word != 24'h040000 || stat_out) hits++;
            end
            chk(hits == 0, "R4", "no time stepping", hits, 0);
        end
        raise_start();
        chk(tune_word == 24'h042000, "R4", "ext step1", tune_word, 24'h042000);
        chk(stat_out == 1'b1, "R7", "incr pulse", stat_out, 1);
        @(negedge clk);
        chk(stat_out == 1'b0, "R7", "pulse width", stat_out, 0);
        cfg_stat_sel = 1'b0;
        idle_low(2);
        raise_start();
        chk(tune_word == 24'h044000, "R5", "ext final", tune_word, 24'h044000);
        chk(stat_out == 1'b1, "R7", "eos pulse", stat_out, 1);
        idle_low(5);
        chk(tune_word == 24'h044000, "R5", "hold last", tune_word, 24'h044000);
        raise_start();
        chk(tune_word == 24'h040000, "R5", "restart", tune_word, 24'h040000);
    endtask

    task automatic t_abort();
        cfg_auto = 1'b1; cfg_start = 24'h100000; cfg_step = 24'h010000;
        cfg_count = 12'd5; cfg_dwell = 16'd50;
        idle_low(3);
        raise_start();
        idle_low(10);
        @(negedge clk) abort_pin = 1'b1;
        repeat (3) @(negedge clk);
        abort_pin = 1'b0;
        chk(tune_word == 24'h0, "R6", "abort tune", tune_word, 0);
        chk(dac_code == 10'd512, "R6", "abort dac", dac_code, 512);
        idle_low(60);
        chk(tune_word == 24'h0 && dac_code == 10'd512, "R6", "stays aborted",
            {tune_word, dac_code}, 512);
        raise_start();
        chk(tune_word == 24'h100000, "R2", "restart after abort", tune_word, 24'h100000);
        idle_low(3);
        @(negedge clk) begin start_pin = 1'b1; abort_pin = 1'b1; end
        repeat (3) @(negedge clk);
        start_pin = 1'b0; abort_pin = 1'b0;
        chk(tune_word == 24'h0, "R6", "abort priority tune", tune_word, 0);
        chk(dac_code == 10'd512, "R6", "abort priority dac", dac_code, 512);
        idle_low(3);
    endtask

    task automatic t_msb();
        int e0, e1;
        cfg_auto = 1'b1; cfg_start = 24'h100000; cfg_step = 24'h0; cfg_count = 12'd1;
        cfg_dwell = 16'd1000;
        idle_low(3);
        raise_start();
        cfg_msb_en = 1'b0; e0 = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (msb_out !== 1'b0) e0++;
        end
        chk(e0 == 0, "R8", "msb disabled", e0, 0);
        cfg_msb_en = 1'b1; e1 = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (msb_out !== ~dac_code[9]) e1++;
        end
        chk(e1 == 0, "R8", "msb tracks", e1, 0);
        cfg_stat_en = 1'b0; cfg_stat_sel = 1'b1; cfg_count = 12'd3; cfg_dwell = 16'd1;
        begin
            int s = 0;
            idle_low(2);
            raise_start();
            for (int i = 0; i < 10; i++) begin
                if (stat_out) s++;
                @(negedge clk);
            end
            chk(s == 0, "R7", "stat disabled", s, 0);
        end
        cfg_stat_en = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_auto(24'h010000, 24'h001000, 3, 4, 1'b1, "R3");
        t_auto(24'h020000, 24'h003000, 3, 4, 1'b0, "R5");
        t_auto(24'h008000, 24'h004000, 2, 0, 1'b1, "R3");
        t_auto(24'h030000, 24'h001000, 0, 4, 1'b0, "R5");
        t_auto(24'h0C0000, 24'hFF8000, 5, 1, 1'b1, "R3");
        t_ext();
        t_abort();
        t_msb();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule